// File: doc/BRIEF.md
# Protected System Instruction Controller

This block watches the stream of fetched 32-bit instruction words and picks out five system-control instructions: software reset, power-down entry, watchdog service, watchdog disable and end-of-initialisation. The low byte of a word selects the opcode. An opcode counts as a protected instruction only when the whole word matches its fixed encoding, so a word damaged in any bit while it was fetched cannot trigger a critical action. When the low byte names a protected opcode but the upper bits do not match, the block raises a decode-error flag for one cycle and takes no other action.

The block drives a reset-out pin and a latched power-down request, and it produces a one-cycle software-reset pulse. It also holds a watchdog down-counter, with its enable, a reload strobe and an underflow reset pulse. End-of-initialisation releases reset-out and seals the watchdog against later disable attempts. After a power-down request, every instruction is ignored until the next hardware reset.

Top module: `psic_top`

## Requirements
- R1: After reset, rst_out is 0, pd_req is 0, wdt_en is 1, wdt_count equals WDT_RELOAD, and swrst_pulse, wdt_reload, wdt_rst and dec_err are all 0.
- R2: A protected word is {~op, ~op, op, op} (bits 31:24, 23:16, 15:8, 7:0), using these opcodes: software reset 8'h3C, power-down 8'h5A, service 8'h69, disable 8'h96, end-of-init 8'hC3. An exact valid software-reset word (32'hC3C33C3C) gives swrst_pulse high for exactly the next cycle.
- R3: A valid word whose low byte is a protected opcode but which differs from that opcode's encoding in any other bit raises dec_err for exactly the next cycle. It causes no other output change.
- R4: A valid word whose low byte is not one of the five opcodes has no effect on any output, and dec_err stays 0.
- R5: An exact service word (32'h96966969) raises wdt_reload for one cycle. In that same cycle wdt_count equals WDT_RELOAD.
- R6: While wdt_en is 1, wdt_count falls by one each cycle. The cycle after it reads 0, wdt_rst is high for one cycle and wdt_count is back at WDT_RELOAD, which is WDT_RELOAD+1 cycles after a reload. A service word accepted while the count is 0 takes priority, and no wdt_rst is produced.
- R7: An exact disable word (32'h69699696) accepted while rst_out is 0 clears wdt_en in the next cycle. From then on wdt_count holds its value and wdt_rst stays 0.
- R8: An exact end-of-init word (32'h3C3CC3C3) sets rst_out to 1 in the next cycle, and it stays 1 until hardware reset. After that, disable words leave wdt_en at 1, and repeated end-of-init words change nothing.
- R9: An exact power-down word (32'hA5A55A5A) sets pd_req in the next cycle, and it stays set until hardware reset. While pd_req is 1, every word is ignored: no swrst_pulse, no dec_err, no change to rst_out.
- R10: A word presented with instr_valid low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| instr_valid | input | 1 | Marks instr_word as a fetched instruction |
| instr_word | input | 32 | Fetched instruction word |
| rst_out | output | 1 | Reset-out pin, low until end-of-init |
| pd_req | output | 1 | Latched power-down request |
| swrst_pulse | output | 1 | One-cycle software-reset pulse |
| wdt_en | output | 1 | Watchdog counter running |
| wdt_reload | output | 1 | One-cycle pulse on accepted service |
| wdt_count | output | WDT_W | Current watchdog count |
| wdt_rst | output | 1 | One-cycle watchdog underflow reset |
| dec_err | output | 1 | One-cycle protected-opcode decode error |

## Verification
A wrong latch state appears at the ports one cycle after the instruction that should have changed it. For example, a lost init latch lets a later disable word clear wdt_en on the following cycle, and a leaking power-down block lets a software-reset word pulse swrst_pulse. Counter faults show up as a wrong count on the very next cycle. An off-by-one in the reload or underflow step moves the wdt_rst pulse by one cycle against the WDT_RELOAD+1 period, and the bench measures that period exactly.

// File: rtl/psic_pkg.sv
package psic_pkg;
  localparam int NUM_OPS  = 5;
  localparam int OP_SRST  = 0;
  localparam int OP_PDN   = 1;
  localparam int OP_SRV   = 2;
  localparam int OP_DIS   = 3;
  localparam int OP_EINIT = 4;

  localparam logic [7:0] OPCODE [NUM_OPS] = '{8'h3C, 8'h5A, 8'h69, 8'h96, 8'hC3};

  // Full protected encoding: two complement bytes, then the opcode twice.
  function automatic logic [31:0] prot_word(input logic [7:0] op);
    return {~op, ~op, op, op};
  endfunction

  // Next watchdog value for one clock while running.
  function automatic logic [63:0] wdt_step(input logic [63:0] cur, input logic [63:0] rld);
    return (cur == 64'd0) ? rld : cur - 64'd1;
  endfunction
endpackage

// File: rtl/psic_decode.sv
module psic_decode
  import psic_pkg::*;
(
  input  logic               valid,
  input  logic [31:0]        word,
  input  logic               block,
  output logic [NUM_OPS-1:0] hit,
  output logic               err
);
  logic [NUM_OPS-1:0] op_sel;
  logic [NUM_OPS-1:0] full_ok;
  logic               live;

  assign live = valid && !block;

  generate
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
      assign op_sel[g]  = (word[7:0] == OPCODE[g]);
      assign full_ok[g] = (word == prot_word(OPCODE[g]));
      assign hit[g]     = live && full_ok[g];
    end
  endgenerate

  assign err = live && (|op_sel) && !(|full_ok);
endmodule

// File: rtl/psic_wdt.sv
module psic_wdt #(
  parameter int WDT_W      = 16,
  parameter int WDT_RELOAD = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             service,
  output logic [WDT_W-1:0] count,
  output logic             underflow
);
  localparam logic [WDT_W-1:0] RLD = WDT_W'(WDT_RELOAD);

  logic [WDT_W-1:0] next_run;
  logic             at_zero;

  assign at_zero  = (count == '0);
  assign next_run = WDT_W'(psic_pkg::wdt_step(64'(count), 64'(RLD)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= RLD;
      underflow <= 1'b0;
    end else begin
      underflow <= run && !service && at_zero;
      if (service)  count <= RLD;
      else if (run) count <= next_run;
    end
  end
endmodule

// File: rtl/psic_ctrl.sv
module psic_ctrl
  import psic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OPS-1:0] hit,
  input  logic               err,
  output logic               rst_out,
  output logic               pd_req,
  output logic               wdt_en,
  output logic               swrst_pulse,
  output logic               wdt_reload,
  output logic               dec_err,
  output logic               dis_blocked
);
  assign dis_blocked = hit[OP_DIS] && rst_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_out     <= 1'b0;
      pd_req      <= 1'b0;
      wdt_en      <= 1'b1;
      swrst_pulse <= 1'b0;
      wdt_reload  <= 1'b0;
      dec_err     <= 1'b0;
    end else begin
      swrst_pulse <= hit[OP_SRST];
      wdt_reload  <= hit[OP_SRV];
      dec_err     <= err;
      if (hit[OP_PDN])                 pd_req  <= 1'b1;
      if (hit[OP_EINIT])               rst_out <= 1'b1;
      if (hit[OP_DIS] && !dis_blocked) wdt_en  <= 1'b0;
    end
  end
endmodule

// File: rtl/psic_top.sv
module psic_top
  import psic_pkg::*;
#(
  parameter int WDT_W      = 16,
  parameter int WDT_RELOAD = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [31:0]      instr_word,
  output logic             rst_out,
  output logic             pd_req,
  output logic             swrst_pulse,
  output logic             wdt_en,
  output logic             wdt_reload,
  output logic [WDT_W-1:0] wdt_count,
  output logic             wdt_rst,
  output logic             dec_err
);
  logic [NUM_OPS-1:0] hit_evt;
  logic               err_evt;
  logic               srv_evt;
  logic               dis_blocked_evt;

  psic_decode u_decode (
    .valid (instr_valid),
    .word  (instr_word),
    .block (pd_req),
    .hit   (hit_evt),
    .err   (err_evt)
  );

  assign srv_evt = hit_evt[OP_SRV];

  psic_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit_evt),
    .err         (err_evt),
    .rst_out     (rst_out),
    .pd_req      (pd_req),
    .wdt_en      (wdt_en),
    .swrst_pulse (swrst_pulse),
    .wdt_reload  (wdt_reload),
    .dec_err     (dec_err),
    .dis_blocked (dis_blocked_evt)
  );

  psic_wdt #(.WDT_W(WDT_W), .WDT_RELOAD(WDT_RELOAD)) u_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (wdt_en),
    .service   (srv_evt),
    .count     (wdt_count),
    .underflow (wdt_rst)
  );
endmodule

// File: rtl/psic_checker.sv
module psic_checker
  import psic_pkg::*;
#(
  parameter int WDT_W      = 16,
  parameter int WDT_RELOAD = 1000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid,
  input logic [31:0]      instr_word,
  input logic             rst_out,
  input logic             pd_req,
  input logic             swrst_pulse,
  input logic             wdt_en,
  input logic             wdt_reload,
  input logic [WDT_W-1:0] wdt_count,
  input logic             wdt_rst,
  input logic             dec_err,
  input logic             dis_blocked_evt
);
  localparam logic [WDT_W-1:0] RLD = WDT_W'(WDT_RELOAD);

  p_swrst_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_pulse |=> !swrst_pulse);

  p_swrst_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_pulse |-> ($past(instr_valid) && !$past(pd_req) &&
                     $past(instr_word) == prot_word(OPCODE[OP_SRST])));

  p_err_no_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (!swrst_pulse && !wdt_reload));

  p_reload_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reload |-> (wdt_count == RLD));

  p_underflow_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (wdt_count == RLD && $past(wdt_count) == '0));

  p_disabled_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> (!wdt_en && !wdt_rst && (wdt_reload || wdt_count == $past(wdt_count))));

  p_rstout_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |=> rst_out);

  p_init_seals_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_blocked_evt && wdt_en) |=> wdt_en);

  p_pd_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> (pd_req && !swrst_pulse && !dec_err && $stable(rst_out)));

  p_invalid_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!swrst_pulse && !dec_err && !wdt_reload));
endmodule

bind psic_top psic_checker #(.WDT_W(WDT_W), .WDT_RELOAD(WDT_RELOAD)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .instr_valid     (instr_valid),
  .instr_word      (instr_word),
  .rst_out         (rst_out),
  .pd_req          (pd_req),
  .swrst_pulse     (swrst_pulse),
  .wdt_en          (wdt_en),
  .wdt_reload      (wdt_reload),
  .wdt_count       (wdt_count),
  .wdt_rst         (wdt_rst),
  .dec_err         (dec_err),
  .dis_blocked_evt (dis_blocked_evt)
);

// File: tb/test_psic_top.sv
module test_psic_top;
  localparam int W   = 8;
  localparam int RLD = 20;

  localparam logic [31:0] W_SRST  = 32'hC3C33C3C;
  localparam logic [31:0] W_PDN   = 32'hA5A55A5A;
  localparam logic [31:0] W_SRV   = 32'h96966969;
  localparam logic [31:0] W_DIS   = 32'h69699696;
  localparam logic [31:0] W_EINIT = 32'h3C3CC3C3;

  // {valid, word, exp swrst, exp dec_err, exp reload}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 32'hC3C33C3C, 3'b100},  // R2 exact reset
    {1'b1, 32'hC3C33C3D, 3'b000},  // R4 low byte not protected
    {1'b1, 32'hC3C33D3C, 3'b010},  // R3 bit 8 flipped
    {1'b1, 32'h43C33C3C, 3'b010},  // R3 bit 31 flipped
    {1'b1, 32'h96966969, 3'b001},  // R5 exact service
    {1'b1, 32'h96966869, 3'b010},  // R3 service damaged
    {1'b0, 32'hC3C33C3C, 3'b000},  // R10 not valid
    {1'b1, 32'h00000000, 3'b000},  // R4
    {1'b1, 32'hA5A55B5A, 3'b010},  // R3 power-down damaged
    {1'b1, 32'h69689696, 3'b010},  // R3 disable damaged
    {1'b1, 32'h3C3CC2C3, 3'b010},  // R3 end-of-init damaged
    {1'b1, 32'hFFFFFF3C, 3'b010}   // R3 upper bits wrong
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_valid = 1'b0;
  logic [31:0]   instr_word = '0;
  logic          rst_out, pd_req, swrst_pulse, wdt_en, wdt_reload, wdt_rst, dec_err;
  logic [W-1:0]  wdt_count;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  psic_top #(.WDT_W(W), .WDT_RELOAD(RLD)) i_psic_top (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .rst_out(rst_out), .pd_req(pd_req), .swrst_pulse(swrst_pulse), .wdt_en(wdt_en),
    .wdt_reload(wdt_reload), .wdt_count(wdt_count), .wdt_rst(wdt_rst), .dec_err(dec_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic apply(input logic v, input logic [31:0] w);
    instr_valid = v;
    instr_word  = w;
    step();
    instr_valid = 1'b0;
    instr_word  = '0;
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual hung expected finish");
      report();
    end
  end

  initial begin
    int k;
    logic [W-1:0] held;
    bit seen;

    // R1 reset state
    do_reset();
    chk("R1 rst_out", rst_out, 0);
    chk("R1 pd_req", pd_req, 0);
    chk("R1 wdt_en", wdt_en, 1);
    chk("R1 count", wdt_count, RLD);
    chk("R1 pulses", {swrst_pulse, wdt_reload, wdt_rst, dec_err}, 0);

    // Vector table: R2 R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][35], VEC[i][34:3]);
      chk("R2 swrst_pulse", swrst_pulse, VEC[i][2]);
      chk("R3 dec_err", dec_err, VEC[i][1]);
      chk("R5 wdt_reload", wdt_reload, VEC[i][0]);
      if (VEC[i][0]) chk("R5 count", wdt_count, RLD);
      chk("R4 latches", {pd_req, rst_out, wdt_en}, 3'b001);
      step();
      chk("R2 one-cycle", {swrst_pulse, dec_err, wdt_reload}, 0);
    end

    // R6 underflow period
    do_reset();
    k = 0;
    while (!wdt_rst && k < 100) begin
      step();
      k++;
    end
    chk("R6 period", k, RLD + 1);
    chk("R6 reload on underflow", wdt_count, RLD);
    step();
    chk("R6 one-cycle", wdt_rst, 0);
    chk("R6 decrement", wdt_count, RLD - 1);

    // R6 service while count is zero wins
    k = 0;
    while (wdt_count != 0 && k < 100) begin
      step();
      k++;
    end
    apply(1'b1, W_SRV);
    chk("R6 collision no wdt_rst", wdt_rst, 0);
    chk("R6 collision reload", wdt_reload, 1);
    chk("R6 collision count", wdt_count, RLD);

    // R7 disable before init
    do_reset();
    apply(1'b1, W_DIS);
    chk("R7 wdt_en", wdt_en, 0);
    held = wdt_count;
    seen = 1'b0;
    repeat (30) begin
      step();
      if (wdt_rst) seen = 1'b1;
    end
    chk("R7 count frozen", wdt_count, held);
    chk("R7 no underflow", seen, 0);

    // R8 end-of-init seals disable
    do_reset();
    apply(1'b1, W_EINIT);
    chk("R8 rst_out", rst_out, 1);
    apply(1'b1, W_DIS);
    chk("R8 disable blocked", wdt_en, 1);
    apply(1'b1, W_EINIT);
    chk("R8 repeat einit", rst_out, 1);
    apply(1'b1, W_DIS);
    chk("R8 disable blocked again", wdt_en, 1);
    held = wdt_count;
    step();
    chk("R8 still counting", wdt_count, held - 1);
    do_reset();
    chk("R8 cleared by reset", rst_out, 0);

    // R9 power-down latch and freeze
    do_reset();
    apply(1'b1, W_PDN);
    chk("R9 pd_req", pd_req, 1);
    apply(1'b1, W_SRST);
    chk("R9 srst ignored", swrst_pulse, 0);
    apply(1'b1, 32'hC3C33D3C);
    chk("R9 error ignored", dec_err, 0);
    apply(1'b1, W_EINIT);
    chk("R9 einit ignored", rst_out, 0);
    repeat (5) step();
    chk("R9 sticky", pd_req, 1);

    done = 1'b1;
    report();
  end
endmodule